// File: doc/BRIEF.md
# Saturating Float-to-Integer Converter

This unit turns an IEEE 754 binary32 or binary64 operand into a 32-bit or 64-bit integer, either signed or unsigned. The source format, destination width, signedness and rounding mode are chosen by control inputs on every cycle. The unit can therefore handle a different kind of conversion in each cycle without any setup.

The unit never traps. A NaN converts to zero. Infinities and finite values that do not fit the destination clamp to the nearest end of the destination's range. Two status flags go with each result: an invalid flag for NaN or a clamped result, and an inexact flag for a rounded result that stayed in range.

The range check is made on the rounded value. The result and both flags are registered, so they appear one clock after the operands are presented.

Top module: `fp2int_sat`

## Requirements
- R1: `src_dbl`=1 takes `op_bits[63:0]` as binary64, and `src_dbl`=0 takes `op_bits[31:0]` as binary32 (the upper bits are ignored). `dst_wide`=1 selects a 64-bit destination and 0 a 32-bit one. `dst_signed`=1 selects a signed destination and 0 an unsigned one.
- R2: Any NaN, quiet or signalling, gives a result of 0 with `flag_invalid`=1 and `flag_inexact`=0.
- R3: +infinity, and rounded values above the destination maximum, give that maximum: 0x7FFFFFFF (i32), 0xFFFFFFFF (u32), 0x7FFFFFFFFFFFFFFF (i64) or 0xFFFFFFFFFFFFFFFF (u64). They also set `flag_invalid`.
- R4: -infinity, and rounded values below the destination minimum, give that minimum: -2^31 or -2^63 for signed destinations and 0 for unsigned ones. They also set `flag_invalid`.
- R5: `rmode`=00 rounds toward zero.
- R6: `rmode`=01 rounds to nearest, with ties going to the even integer.
- R7: `rmode`=10 rounds toward minus infinity, and `rmode`=11 rounds toward plus infinity.
- R8: Saturation is decided after rounding. For example, 2^31-0.5 gives 0x7FFFFFFF with `flag_inexact` under truncation, and saturates with `flag_invalid` under nearest-even for i32.
- R9: For an unsigned destination, a negative input that rounds to zero gives 0 with `flag_invalid`=0. A negative input that rounds to -1 or below gives 0 with `flag_invalid`=1.
- R10: `flag_inexact` is 1 exactly when nonzero fraction bits were discarded and the result was neither saturated nor from a NaN. The two flags are never both 1.
- R11: Signed zeros and subnormals give 0. The exceptions are that floor gives -1 for a negative subnormal and ceiling gives 1 for a positive subnormal.
- R12: A 32-bit result is placed in `result[31:0]`. It is sign-extended for a signed destination and zero-extended for an unsigned one.
- R13: The result and flags are registered and are valid one clock after the inputs. While `rst_n` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_bits | input | 64 | Floating-point operand bits |
| src_dbl | input | 1 | 1 = binary64, 0 = binary32 in low half |
| dst_wide | input | 1 | 1 = 64-bit destination, 0 = 32-bit |
| dst_signed | input | 1 | 1 = signed destination |
| rmode | input | 2 | 00 trunc, 01 nearest-even, 10 floor, 11 ceiling |
| result | output | 64 | Converted integer |
| flag_inexact | output | 1 | Discarded fraction, no saturation |
| flag_invalid | output | 1 | NaN or saturated |

## Verification
Every result and both flags are due exactly one rising edge after the operand and controls are applied. The bench therefore drives new values on a falling edge and compares on the following falling edge, after the single capturing edge. Each operation is checked in isolation, so a wrong latency shows up as a mismatch. The checker's timed properties look one cycle back from an output to the inputs that produced it.

// File: rtl/fp2int_sat.sv
module fp2int_sat #(
  parameter int OUT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [63:0]      op_bits,
  input  logic             src_dbl,
  input  logic             dst_wide,
  input  logic             dst_signed,
  input  logic [1:0]       rmode,
  output logic [OUT_W-1:0] result,
  output logic             flag_inexact,
  output logic             flag_invalid
);
  localparam int MW  = 53;
  localparam int SHW = 3 * OUT_W;

  logic              sgn, exp_ones, exp_zero;
  logic [51:0]       frac;
  logic signed [12:0] unb;
  logic [MW-1:0]     mant;

  always_comb begin
    if (src_dbl) begin
      sgn      = op_bits[63];
      exp_ones = &op_bits[62:52];
      exp_zero = ~|op_bits[62:52];
      frac     = op_bits[51:0];
      unb      = exp_zero ? -13'sd1022 : $signed({2'b00, op_bits[62:52]}) - 13'sd1023;
    end else begin
      sgn      = op_bits[31];
      exp_ones = &op_bits[30:23];
      exp_zero = ~|op_bits[30:23];
      frac     = {op_bits[22:0], 29'b0};
      unb      = exp_zero ? -13'sd126 : $signed({5'b00000, op_bits[30:23]}) - 13'sd127;
    end
    mant = {~exp_zero, frac};
  end

  wire is_nan = exp_ones & (|frac);
  wire is_inf = exp_ones & ~(|frac);
  wire huge   = is_inf | (unb > 13'sd63);
  wire tiny   = unb < -13'sd64;

  logic [6:0]       amt;
  logic [SHW-1:0]   shifted;
  logic [OUT_W-1:0] ipart;
  logic             rbit, sbit;

  always_comb begin
    amt     = 7'(13'sd63 - unb);
    shifted = {mant, {(SHW-MW){1'b0}}} >> amt;
    if (tiny) begin
      ipart = '0;
      rbit  = 1'b0;
      sbit  = |mant;
    end else begin
      ipart = shifted[SHW-1 -: OUT_W];
      rbit  = shifted[SHW-OUT_W-1];
      sbit  = |shifted[SHW-OUT_W-2:0];
    end
  end

  wire lost = rbit | sbit;

  logic bump;
  always_comb begin
    unique case (rmode)
      2'b00:   bump = 1'b0;
      2'b01:   bump = rbit & (sbit | ipart[0]);
      2'b10:   bump = sgn & lost;
      default: bump = ~sgn & lost;
    endcase
  end

  wire [OUT_W:0] mag = {1'b0, ipart} + {{OUT_W{1'b0}}, bump};

  logic [OUT_W:0] pos_lim, neg_lim;
  always_comb begin
    pos_lim = '0;
    neg_lim = '0;
    if (dst_signed) begin
      pos_lim[dst_wide ? 63 : 31] = 1'b1;
      neg_lim = pos_lim;
      pos_lim = pos_lim - 1'b1;
    end else begin
      pos_lim[dst_wide ? 64 : 32] = 1'b1;
      pos_lim = pos_lim - 1'b1;
    end
  end

  wire sat_hi = ~is_nan & ~sgn & (huge | (mag > pos_lim));
  wire sat_lo = ~is_nan &  sgn & (huge | (mag > neg_lim));

  logic [OUT_W-1:0] nxt;
  always_comb begin
    if (is_nan)      nxt = '0;
    else if (sat_hi) nxt = pos_lim[OUT_W-1:0];
    else if (sat_lo) nxt = -neg_lim[OUT_W-1:0];
    else if (sgn)    nxt = -mag[OUT_W-1:0];
    else             nxt = mag[OUT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result       <= '0;
      flag_inexact <= 1'b0;
      flag_invalid <= 1'b0;
    end else begin
      result       <= nxt;
      flag_invalid <= is_nan | sat_hi | sat_lo;
      flag_inexact <= lost & ~(is_nan | sat_hi | sat_lo);
    end
  end
endmodule

// File: rtl/fp2int_sat_chk.sv
module fp2int_sat_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [63:0] op_bits,
  input logic        src_dbl,
  input logic        dst_wide,
  input logic        dst_signed,
  input logic [63:0] result,
  input logic        flag_inexact,
  input logic        flag_invalid
);
  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  wire in_nan = src_dbl ? ((&op_bits[62:52]) & (|op_bits[51:0]))
                        : ((&op_bits[30:23]) & (|op_bits[22:0]));

  AST_NAN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(in_nan) |-> (result == 64'd0) && flag_invalid && !flag_inexact); // R2

  AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(flag_invalid && flag_inexact)); // R10

  AST_UNS_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(!dst_signed) && flag_invalid |->
      (result == 64'd0) || (result == ($past(dst_wide) ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0000_0000_FFFF_FFFF))); // R9

  AST_NARROW_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(!dst_wide) |->
      (result[63:32] == ($past(dst_signed) ? {32{result[31]}} : 32'd0))); // R12
endmodule

bind fp2int_sat fp2int_sat_chk u_chk (
  .clk(clk), .rst_n(rst_n), .op_bits(op_bits), .src_dbl(src_dbl),
  .dst_wide(dst_wide), .dst_signed(dst_signed), .result(result),
  .flag_inexact(flag_inexact), .flag_invalid(flag_invalid)
);

// File: tb/fp2int_sat_tb.sv
`timescale 1ns/1ps
module fp2int_sat_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [63:0] op_bits = '0;
  logic src_dbl = 1'b0, dst_wide = 1'b0, dst_signed = 1'b0;
  logic [1:0] rmode = 2'b00;
  logic [63:0] result;
  logic flag_inexact, flag_invalid;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  fp2int_sat u_dut (
    .clk(clk), .rst_n(rst_n), .op_bits(op_bits), .src_dbl(src_dbl),
    .dst_wide(dst_wide), .dst_signed(dst_signed), .rmode(rmode),
    .result(result), .flag_inexact(flag_inexact), .flag_invalid(flag_invalid)
  );

  function automatic void model(input logic [63:0] op, input bit dbl, input bit wide,
                                input bit sg, input bit [1:0] rm,
                                output logic [63:0] r, output bit inx, output bit inv);
    bit s, nan, inf, big, up, fnz;
    int e, ex, cmp, d;
    logic [127:0] m, ip, rem, half;
    logic signed [67:0] v, hi, lo;
    big = 0; rem = '0; cmp = -1; ip = '0;
    if (dbl) begin
      s = op[63]; ex = int'(op[62:52]);
      m = {76'd0, op[51:0]};
      nan = (ex == 2047) && (op[51:0] != 0); inf = (ex == 2047) && (op[51:0] == 0);
      if (ex == 0) e = -1074; else begin m[52] = 1'b1; e = ex - 1075; end
    end else begin
      s = op[31]; ex = int'(op[30:23]);
      m = {105'd0, op[22:0]};
      nan = (ex == 255) && (op[22:0] != 0); inf = (ex == 255) && (op[22:0] == 0);
      if (ex == 0) e = -149; else begin m[23] = 1'b1; e = ex - 150; end
    end
    if (e >= 0) begin
      if (e >= 70) big = 1; else ip = m << e;
    end else begin
      d = -e;
      if (d > 120) begin ip = '0; rem = m; cmp = -1; end
      else begin
        ip = m >> d;
        rem = m & ((128'd1 << d) - 128'd1);
        half = 128'd1 << (d - 1);
        cmp = (rem < half) ? -1 : (rem == half) ? 0 : 1;
      end
    end
    fnz = (rem != 0);
    case (rm)
      2'b00: up = 0;
      2'b01: up = (cmp > 0) || (cmp == 0 && ip[0]);
      2'b10: up = s && fnz;
      default: up = !s && fnz;
    endcase
    ip = ip + 128'(up);
    if (ip >= (128'd1 << 66)) big = 1;
    v = s ? -$signed({1'b0, ip[66:0]}) : $signed({1'b0, ip[66:0]});
    if (sg) begin
      hi = wide ? (68'sd1 <<< 63) - 68'sd1 : (68'sd1 <<< 31) - 68'sd1;
      lo = wide ? -(68'sd1 <<< 63) : -(68'sd1 <<< 31);
    end else begin
      hi = wide ? (68'sd1 <<< 64) - 68'sd1 : (68'sd1 <<< 32) - 68'sd1;
      lo = 68'sd0;
    end
    if (nan) begin r = '0; inv = 1; inx = 0; end
    else if ((inf || big || v > hi) && !s) begin r = hi[63:0]; inv = 1; inx = 0; end
    else if ((inf || big || v < lo) && s)  begin r = lo[63:0]; inv = 1; inx = 0; end
    else begin r = v[63:0]; inv = 0; inx = fnz; end
  endfunction

  task automatic apply(input logic [63:0] op, input bit dbl, input bit wide, input bit sg,
                       input bit [1:0] rm);
    @(negedge clk);
    op_bits = op; src_dbl = dbl; dst_wide = wide; dst_signed = sg; rmode = rm;
    @(negedge clk);
  endtask

  task automatic compare(input string tag, input logic [63:0] er, input bit ex, input bit ev);
    checks++;
    if (result !== er || flag_inexact !== ex || flag_invalid !== ev) begin
      errors++;
      $display("FAIL %s: got res=%h inx=%0b inv=%0b, expected res=%h inx=%0b inv=%0b",
               tag, result, flag_inexact, flag_invalid, er, ex, ev);
    end
  endtask

  task automatic dir(input string tag, input logic [63:0] op, input bit dbl, input bit wide,
                     input bit sg, input bit [1:0] rm,
                     input logic [63:0] er, input bit ex, input bit ev);
    apply(op, dbl, wide, sg, rm);
    compare(tag, er, ex, ev);
  endtask

  task automatic rnd(input string tag, input logic [63:0] op, input bit dbl, input bit wide,
                     input bit sg, input bit [1:0] rm);
    logic [63:0] er; bit ex, ev;
    model(op, dbl, wide, sg, rm, er, ex, ev);
    apply(op, dbl, wide, sg, rm);
    compare(tag, er, ex, ev);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20210530));
    op_bits = 64'h7FF8_0000_0000_0000; src_dbl = 1;
    repeat (3) @(negedge clk);
    compare("R13 reset", 64'd0, 0, 0);
    rst_n = 1'b1;

    dir("R2 qnan64",  64'h7FF8_0000_0000_0000, 1, 1, 1, 2'b00, 64'd0, 0, 1);
    dir("R2 snan32",  64'h0000_0000_FF80_0001, 0, 0, 0, 2'b11, 64'd0, 0, 1);
    dir("R3 +inf i32", 64'h0000_0000_7F80_0000, 0, 0, 1, 2'b00, 64'h0000_0000_7FFF_FFFF, 0, 1);
    dir("R3 +inf u32", 64'h7FF0_0000_0000_0000, 1, 0, 0, 2'b00, 64'h0000_0000_FFFF_FFFF, 0, 1);
    dir("R3 2^64 u64", 64'h0000_0000_5F80_0000, 0, 1, 0, 2'b00, 64'hFFFF_FFFF_FFFF_FFFF, 0, 1);
    dir("R4 -inf i64", 64'hFFF0_0000_0000_0000, 1, 1, 1, 2'b01, 64'h8000_0000_0000_0000, 0, 1);
    dir("R4 -inf i32", 64'h0000_0000_FF80_0000, 0, 0, 1, 2'b00, 64'hFFFF_FFFF_8000_0000, 0, 1);
    dir("R5 trunc 2.5", 64'h4004_0000_0000_0000, 1, 1, 1, 2'b00, 64'd2, 1, 0);
    dir("R6 rne 2.5", 64'h4004_0000_0000_0000, 1, 1, 1, 2'b01, 64'd2, 1, 0);
    dir("R6 rne 3.5", 64'h400C_0000_0000_0000, 1, 1, 1, 2'b01, 64'd4, 1, 0);
    dir("R7 floor -2.5", 64'hC004_0000_0000_0000, 1, 1, 1, 2'b10, 64'hFFFF_FFFF_FFFF_FFFD, 1, 0);
    dir("R7 ceil 2.5", 64'h4004_0000_0000_0000, 1, 1, 1, 2'b11, 64'd3, 1, 0);
    dir("R8 trunc 2^31-0.5", 64'h41DF_FFFF_FFE0_0000, 1, 0, 1, 2'b00, 64'h0000_0000_7FFF_FFFF, 1, 0);
    dir("R8 rne 2^31-0.5", 64'h41DF_FFFF_FFE0_0000, 1, 0, 1, 2'b01, 64'h0000_0000_7FFF_FFFF, 0, 1);
    dir("R9 -0.3 trunc u32", 64'h0000_0000_BE99_999A, 0, 0, 0, 2'b00, 64'd0, 1, 0);
    dir("R9 -0.3 ceil u32", 64'h0000_0000_BE99_999A, 0, 0, 0, 2'b11, 64'd0, 1, 0);
    dir("R9 -0.3 floor u32", 64'h0000_0000_BE99_999A, 0, 0, 0, 2'b10, 64'd0, 0, 1);
    dir("R10 exact 1.0", 64'h0000_0000_3F80_0000, 0, 1, 0, 2'b01, 64'd1, 0, 0);
    dir("R11 -0.0", 64'h8000_0000_0000_0000, 1, 1, 1, 2'b10, 64'd0, 0, 0);
    dir("R11 sub ceil", 64'h0000_0000_0000_0001, 1, 1, 1, 2'b11, 64'd1, 1, 0);
    dir("R11 sub floor", 64'h0000_0000_0000_0001, 1, 1, 1, 2'b10, 64'd0, 1, 0);
    dir("R11 -sub floor", 64'h0000_0000_8000_0001, 0, 1, 1, 2'b10, 64'hFFFF_FFFF_FFFF_FFFF, 1, 0);
    dir("R12 -1.0 i32", 64'h0000_0000_BF80_0000, 0, 0, 1, 2'b00, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0);
    dir("R12 3e9 u32", 64'h41E6_5A0B_C000_0000, 1, 0, 0, 2'b00, 64'h0000_0000_B2D0_5E00, 0, 0);
    dir("R1 upper ignored", 64'hDEAD_BEEF_4040_0000, 0, 1, 1, 2'b00, 64'd3, 0, 0);

    for (int i = 0; i < 4000; i++) begin
      logic [63:0] op;
      bit dbl, wide, sg;
      bit [1:0] rm;
      int ex;
      dbl = $urandom_range(0, 1); wide = $urandom_range(0, 1);
      sg = $urandom_range(0, 1); rm = 2'($urandom_range(0, 3));
      op = {$urandom, $urandom};
      if ($urandom_range(0, 9) < 8) begin
        if (dbl) begin
          ex = 1023 + $urandom_range(0, 80) - 12;
          op[62:52] = 11'(ex);
        end else begin
          ex = 127 + $urandom_range(0, 80) - 12;
          op[30:23] = 8'(ex);
        end
      end
      rnd("R1 R5 R6 R7 random", op, dbl, wide, sg, rm);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule